// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out where a 32-bit RISC-style core fetches next. It takes the current program counter, the instruction word and the two source operand values, and returns the next PC. It also returns a redirect flag, the return address to be written back, a write enable for that return address, and two fault flags. It covers the three control-flow classes: conditional branches, the direct jump-and-link and the register-indirect jump-and-link. Every other opcode simply advances the PC by four.

The block rebuilds the branch and jump offsets, whose bits the instruction word carries out of order. It evaluates one of six compare conditions selected by the funct3 field. It clears bit 0 of a register-indirect target. A redirect to a target that is not word aligned is reported as a fault and leaves the PC where it was. Reserved compare encodings are also reported as faults. A parameter selects between a registered output stage (default, one cycle of latency) and a purely combinational path.

Top module: `npc_unit`

## Requirements
- R1: For a branch (instr[6:0] = 1100011) whose condition holds, next_pc = pc_in + sext(off), where off[12] = instr[31], off[11] = instr[7], off[10:5] = instr[30:25], off[4:1] = instr[11:8] and off[0] = 0. taken = 1 and link_we = 0.
- R2: The branch condition is selected by funct3 = instr[14:12]: 000 is rs1 == rs2, 001 is rs1 != rs2, 100 is signed rs1 < rs2, 101 is signed rs1 >= rs2, 110 is unsigned rs1 < rs2 and 111 is unsigned rs1 >= rs2.
- R3: A branch whose condition fails, and any opcode other than the three control-flow opcodes, gives next_pc = pc_in + 4 with taken = 0, link_we = 0, misalign = 0 and illegal = 0.
- R4: For the direct jump (instr[6:0] = 1101111), next_pc = pc_in + sext(off), where off[20] = instr[31], off[19:12] = instr[19:12], off[11] = instr[20], off[10:1] = instr[30:21] and off[0] = 0. taken = 1 and link_val = pc_in + 4.
- R5: For the indirect jump (instr[6:0] = 1100111 with funct3 000), next_pc = (rs1_val + sext(instr[31:20])) with bit 0 forced to 0. taken = 1 and link_val = pc_in + 4.
- R6: link_we is 1 only for a jump that redirects and has rd = instr[11:7] not equal to 0. link_val is pc_in + 4 for every accepted instruction.
- R7: When a redirect target has bit 1 set, misalign = 1, taken = 0, link_we = 0 and next_pc = pc_in. At most one of taken, misalign and illegal is set at a time.
- R8: A branch with funct3 010 or 011, or the indirect jump with funct3 other than 000, sets illegal = 1, taken = 0, link_we = 0 and next_pc = pc_in.
- R9: With the registered stage, the outputs for an instruction presented with in_valid = 1 appear one clock later with out_valid = 1. out_valid is 0 in the cycle after in_valid = 0. Reset clears out_valid and all result outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present |
| pc_in | input | XLEN | PC of the instruction |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | First source operand |
| rs2_val | input | XLEN | Second source operand |
| out_valid | output | 1 | Results are valid |
| next_pc | output | XLEN | Next fetch address |
| taken | output | 1 | Control flow redirected |
| link_val | output | XLEN | Return address (PC + 4) |
| link_we | output | 1 | Write the return address to rd |
| misalign | output | 1 | Redirect target not word aligned |
| illegal | output | 1 | Reserved control-flow encoding |

## Verification
Every result of this block (next_pc, taken, link_val, link_we and both fault flags) is due exactly one rising edge after the instruction is driven with in_valid high. The bench drives each instruction on a falling edge and compares all outputs on the following falling edge, half a period after the capturing edge. An idle cycle is checked the same way, and out_valid must be low there. Expected values come from a bench function that decodes the instruction word independently. That function is applied to directed corner cases (offset extremes, the sign of the compares, bit-0 clearing, faults, rd = 0) and to seeded random instructions.

// File: rtl/npc_pkg.sv
package npc_pkg;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;

   typedef enum logic [2:0] {
      CMP_EQ  = 3'b000,
      CMP_NE  = 3'b001,
      CMP_RS0 = 3'b010,
      CMP_RS1 = 3'b011,
      CMP_LT  = 3'b100,
      CMP_GE  = 3'b101,
      CMP_LTU = 3'b110,
      CMP_GEU = 3'b111
   } cmp_e;
endpackage

// File: rtl/npc_imm_decode.sv
module npc_imm_decode #(
   parameter int XLEN = 32
) (
   input  logic [31:7]     ins,
   output logic [XLEN-1:0] br_off,
   output logic [XLEN-1:0] jmp_off,
   output logic [XLEN-1:0] ind_off
);
   localparam int BR_EXT  = XLEN - 12;
   localparam int JMP_EXT = XLEN - 20;

   // branch offset: sign, bit 11, bits 10:5, bits 4:1, zero
   assign br_off  = {{BR_EXT{ins[31]}}, ins[7], ins[30:25], ins[11:8], 1'b0};
   // jump offset: sign, bits 19:12, bit 11, bits 10:1, zero
   assign jmp_off = {{JMP_EXT{ins[31]}}, ins[19:12], ins[20], ins[30:21], 1'b0};
   // indirect offset: plain 12-bit field
   assign ind_off = {{BR_EXT{ins[31]}}, ins[31:20]};

   // ins[6:0] not needed here; range chosen so no bit goes unused
endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic [2:0]      sel,
   output logic            hit,
   output logic            reserved
);
   import npc_pkg::*;

   logic eq, lt_s, lt_u;

   assign eq   = (a == b);
   assign lt_s = ($signed(a) < $signed(b));
   assign lt_u = (a < b);

   always_comb begin
      hit      = 1'b0;
      reserved = 1'b0;
      case (cmp_e'(sel))
         CMP_EQ:  hit = eq;
         CMP_NE:  hit = !eq;
         CMP_LT:  hit = lt_s;
         CMP_GE:  hit = !lt_s;
         CMP_LTU: hit = lt_u;
         CMP_GEU: hit = !lt_u;
         default: reserved = 1'b1;
      endcase
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
   parameter int XLEN    = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [XLEN-1:0] pc_in,
   input  logic [31:0]     instr,
   input  logic [XLEN-1:0] rs1_val,
   input  logic [XLEN-1:0] rs2_val,
   output logic            out_valid,
   output logic [XLEN-1:0] next_pc,
   output logic            taken,
   output logic [XLEN-1:0] link_val,
   output logic            link_we,
   output logic            misalign,
   output logic            illegal
);
   import npc_pkg::*;

   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("npc_unit: XLEN must be 32 or 64");
      end
   endgenerate

   logic [6:0]      opc;
   logic [2:0]      f3;
   logic [4:0]      rd;
   logic [XLEN-1:0] br_off, jmp_off, ind_off;
   logic            cond_hit, cond_rsvd;

   assign opc = instr[6:0];
   assign f3  = instr[14:12];
   assign rd  = instr[11:7];

   npc_imm_decode #(.XLEN(XLEN)) u_imm (
      .ins     (instr[31:7]),
      .br_off  (br_off),
      .jmp_off (jmp_off),
      .ind_off (ind_off)
   );

   npc_cond_eval #(.XLEN(XLEN)) u_cmp (
      .a        (rs1_val),
      .b        (rs2_val),
      .sel      (f3),
      .hit      (cond_hit),
      .reserved (cond_rsvd)
   );

   logic [XLEN-1:0] seq_c, tgt_c, ind_sum, np_c;
   logic            redir_c, want_link, ill_c, mis_c, tk_c, we_c;

   assign ind_sum = rs1_val + ind_off;

   always_comb begin
      seq_c     = pc_in + STEP;
      tgt_c     = seq_c;
      redir_c   = 1'b0;
      want_link = 1'b0;
      ill_c     = 1'b0;
      case (opc)
         OPC_BRANCH: begin
            if (cond_rsvd) ill_c = 1'b1;
            else if (cond_hit) begin
               redir_c = 1'b1;
               tgt_c   = pc_in + br_off;
            end
         end
         OPC_JAL: begin
            redir_c   = 1'b1;
            want_link = 1'b1;
            tgt_c     = pc_in + jmp_off;
         end
         OPC_JALR: begin
            if (f3 != 3'b000) ill_c = 1'b1;
            else begin
               redir_c   = 1'b1;
               want_link = 1'b1;
               tgt_c     = {ind_sum[XLEN-1:1], 1'b0};
            end
         end
         default: ;
      endcase
      mis_c = redir_c && tgt_c[1];
      tk_c  = redir_c && !mis_c;
      we_c  = tk_c && want_link && (rd != 5'd0);
      np_c  = (ill_c || mis_c) ? pc_in : tgt_c;
   end

   logic [XLEN-1:0] pc_q;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               next_pc   <= '0;
               taken     <= 1'b0;
               link_val  <= '0;
               link_we   <= 1'b0;
               misalign  <= 1'b0;
               illegal   <= 1'b0;
               pc_q      <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  next_pc  <= np_c;
                  taken    <= tk_c;
                  link_val <= seq_c;
                  link_we  <= we_c;
                  misalign <= mis_c;
                  illegal  <= ill_c;
                  pc_q     <= pc_in;
               end
            end
         end
      end else begin : g_comb
         assign out_valid = in_valid;
         assign next_pc   = np_c;
         assign taken     = tk_c;
         assign link_val  = seq_c;
         assign link_we   = we_c;
         assign misalign  = mis_c;
         assign illegal   = ill_c;
         assign pc_q      = pc_in;
      end
   endgenerate

   // ---------------- assertions ----------------
   assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $onehot0({taken, misalign, illegal}));

   assert_fault_holds_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (misalign || illegal) |-> (next_pc == pc_q) && !link_we);

   assert_taken_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && taken |-> !next_pc[1]);

   assert_link_needs_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && link_we |-> taken && (link_val == pc_q + STEP));

   assert_fallthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !taken && !misalign && !illegal |-> next_pc == pc_q + STEP);
endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] pc_in = '0, instr = '0, rs1_val = '0, rs2_val = '0;
   logic        out_valid, taken, link_we, misalign, illegal;
   logic [31:0] next_pc, link_val;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   npc_unit #(.XLEN(32), .REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_in(pc_in),
      .instr(instr), .rs1_val(rs1_val), .rs2_val(rs2_val),
      .out_valid(out_valid), .next_pc(next_pc), .taken(taken),
      .link_val(link_val), .link_we(link_we), .misalign(misalign),
      .illegal(illegal)
   );

   typedef struct packed {
      logic [31:0] np;
      logic        tk;
      logic [31:0] lk;
      logic        we;
      logic        mis;
      logic        ill;
   } exp_t;

   // independent reference decode
   function automatic exp_t model(input logic [31:0] pc, input logic [31:0] w,
                                  input logic [31:0] a, input logic [31:0] b);
      exp_t e;
      logic [12:0] bo;
      logic [20:0] jo;
      logic [31:0] tgt;
      bit redir, lnk, cnd;
      int unsigned f3;
      f3 = w[14:12];
      bo = {w[31], w[7], w[30:25], w[11:8], 1'b0};
      jo = {w[31], w[19:12], w[20], w[30:21], 1'b0};
      e = '0;
      e.lk = pc + 32'd4;
      redir = 0; lnk = 0; cnd = 0; tgt = 0;
      if (w[6:0] == 7'b1100011) begin
         if (f3 == 2 || f3 == 3) e.ill = 1;
         else begin
            case (f3)
               0: cnd = (a == b);
               1: cnd = (a != b);
               4: cnd = ($signed(a) < $signed(b));
               5: cnd = ($signed(a) >= $signed(b));
               6: cnd = (a < b);
               default: cnd = (a >= b);
            endcase
            if (cnd) begin redir = 1; tgt = pc + 32'($signed(bo)); end
         end
      end else if (w[6:0] == 7'b1101111) begin
         redir = 1; lnk = 1; tgt = pc + 32'($signed(jo));
      end else if (w[6:0] == 7'b1100111) begin
         if (f3 != 0) e.ill = 1;
         else begin
            redir = 1; lnk = 1;
            tgt = (a + 32'($signed(w[31:20]))) & 32'hFFFF_FFFE;
         end
      end
      if (e.ill) e.np = pc;
      else if (redir && tgt[1]) begin e.mis = 1; e.np = pc; end
      else if (redir) begin e.np = tgt; e.tk = 1; e.we = lnk && (w[11:7] != 0); end
      else e.np = pc + 32'd4;
      return e;
   endfunction

   function automatic logic [31:0] enc_br(input int off, input logic [2:0] f3);
      logic [12:0] o = 13'(off);
      return {o[12], o[10:5], 5'd2, 5'd1, f3, o[4:1], o[11], 7'b1100011};
   endfunction

   function automatic logic [31:0] enc_jal(input int off, input logic [4:0] rd);
      logic [20:0] o = 21'(off);
      return {o[20], o[10:1], o[11], o[19:12], rd, 7'b1101111};
   endfunction

   function automatic logic [31:0] enc_jalr(input int off, input logic [2:0] f3,
                                            input logic [4:0] rd);
      logic [11:0] o = 12'(off);
      return {o, 5'd1, f3, rd, 7'b1100111};
   endfunction

   task automatic run(input logic [31:0] pc, input logic [31:0] w,
                      input logic [31:0] a, input logic [31:0] b, input string tag);
      exp_t e, g;
      @(negedge clk);
      pc_in = pc; instr = w; rs1_val = a; rs2_val = b; in_valid = 1'b1;
      e = model(pc, w, a, b);
      @(negedge clk);
      in_valid = 1'b0;
      g = '{np: next_pc, tk: taken, lk: link_val, we: link_we, mis: misalign, ill: illegal};
      n_chk++;
      if (!out_valid || g != e) begin
         n_bad++;
         $display("FAIL %s (R9 valid=%0b): got np=%h tk=%0b lk=%h we=%0b mis=%0b ill=%0b exp np=%h tk=%0b lk=%h we=%0b mis=%0b ill=%0b",
                  tag, out_valid, g.np, g.tk, g.lk, g.we, g.mis, g.ill,
                  e.np, e.tk, e.lk, e.we, e.mis, e.ill);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E_3D4C));
      repeat (3) @(negedge clk);
      // R9: reset state
      n_chk++;
      if (out_valid || next_pc != 0 || taken || link_val != 0 || link_we || misalign || illegal) begin
         n_bad++;
         $display("FAIL R9 reset: got valid=%0b np=%h exp all zero", out_valid, next_pc);
      end
      rst_n = 1'b1;

      run(32'h1000, enc_br(16, 3'b000), 32'd7, 32'd7, "R1 R2 beq taken fwd");
      run(32'h2000, enc_br(-4096, 3'b001), 32'd1, 32'd2, "R1 bne min offset");
      run(32'h3000, enc_br(4092, 3'b001), 32'd1, 32'd2, "R1 bne max offset");
      run(32'h1000, enc_br(16, 3'b000), 32'd7, 32'd8, "R3 beq not taken");
      run(32'h1000, enc_br(32, 3'b100), 32'hFFFF_FFFF, 32'd1, "R2 blt signed taken");
      run(32'h1000, enc_br(32, 3'b110), 32'hFFFF_FFFF, 32'd1, "R2 R3 bltu not taken");
      run(32'h1000, enc_br(-32, 3'b101), 32'd5, 32'd5, "R2 bge equal");
      run(32'h1000, enc_br(-32, 3'b111), 32'h8000_0000, 32'd1, "R2 bgeu");
      run(32'h1000, enc_br(8, 3'b010), 32'd0, 32'd0, "R8 reserved 010");
      run(32'h1000, enc_br(8, 3'b011), 32'd0, 32'd0, "R8 reserved 011");
      run(32'h0010_0000, enc_jal(1048574 & ~3, 5'd1), 0, 0, "R4 jal max fwd");
      run(32'h0010_0000, enc_jal(-1048576, 5'd5), 0, 0, "R4 jal min");
      run(32'h4000, enc_jal(64, 5'd0), 0, 0, "R6 jal rd zero");
      run(32'h4000, enc_jalr(0, 3'b000, 5'd1), 32'h3001, 0, "R5 jalr clear bit0");
      run(32'h4000, enc_jalr(-8, 3'b000, 5'd3), 32'h5000, 0, "R5 jalr neg off");
      run(32'h4000, enc_jalr(0, 3'b001, 5'd1), 32'h3000, 0, "R8 jalr bad funct3");
      run(32'h1000, enc_br(6, 3'b000), 32'd0, 32'd0, "R7 misaligned branch");
      run(32'h4000, enc_jalr(2, 3'b000, 5'd1), 32'h3000, 0, "R7 misaligned jalr");
      run(32'h1234, 32'h0050_0093, 32'd9, 0, "R3 non-control addi");

      // R9: idle cycle gives out_valid low
      @(negedge clk);
      @(negedge clk);
      n_chk++;
      if (out_valid) begin
         n_bad++;
         $display("FAIL R9 idle: got out_valid=1 exp 0");
      end

      for (int i = 0; i < 400; i++) begin
         logic [31:0] w, a, b, pc;
         int unsigned sel;
         w   = $urandom;
         a   = $urandom;
         b   = $urandom;
         pc  = $urandom & 32'hFFFF_FFFC;
         sel = $urandom % 5;
         case (sel)
            0: w[6:0] = 7'b1100011;
            1: begin w[6:0] = 7'b1100011; b = a; end
            2: w[6:0] = 7'b1101111;
            3: w[6:0] = 7'b1100111;
            default: w[6:0] = 7'b0110011;
         endcase
         run(pc, w, a, b, "R1 R2 R4 R5 R6 random");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule